// File: doc/BRIEF.md
# Bit Test Flag Unit

This block evaluates a single bit of a 32-bit data word and folds the result into a packed condition-flag word. The caller picks the bit position in one of two ways. It can take the low five bits of a register operand, or a short 4-bit immediate that is widened with zeros. The block writes nothing back to the data operand. Its only product is a new flag word, and that word differs from the incoming one in three bit positions only.

Two flags are written from the test. The negative flag (bit 3) copies the chosen bit. The zero flag (bit 2) is set only when the chosen bit and every bit below it are all clear, so it does not test the chosen bit alone. The extend flag (bit 4) is always cleared. All other flag bits pass through unchanged.

The data path is a one-beat stream with no back-pressure. A request is taken in any cycle where `in_valid` is high. One clock later the result appears on `flags_out`, and `flags_we` is high for exactly that one cycle. The consumer must take every result in the cycle it is offered, because the block has no ready input and stores no second result. Between results, `flags_out` keeps the last value it produced.

Top module: `btst_unit`

## Requirements
- R1: In register-index form (`use_imm`=0) the bit position is `reg_index[4:0]`, and bits 31:5 of `reg_index` have no effect.
- R2: In immediate form (`use_imm`=1) the bit position is `imm_index` widened with a zero in bit 4, so positions 0 to 15 can be reached, and `reg_index` has no effect.
- R3: Flag bit 3 (negative) of the result equals `in_data` at the selected position.
- R4: Flag bit 2 (zero) of the result is 1 exactly when `in_data` bits from the selected position down to bit 0 are all zero.
- R5: At position 31 the zero flag covers all 32 data bits, so it is 1 only for an all-zero data word.
- R6: Flag bit 4 (extend) of the result is always 0.
- R7: Every flag bit other than bits 2, 3 and 4 equals the corresponding bit of `flags_in` sampled with the request.
- R8: `flags_we` is high in exactly the cycle after each cycle with `in_valid` high, and `flags_out` holds its value in every cycle that has no result.
- R9: While reset is held, and after it is released, `flags_we` is 0 and `flags_out` is all zeros until the first result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; one test per high cycle |
| in_data | input | 32 | Data word whose bit is tested |
| use_imm | input | 1 | 1 selects the immediate position, 0 selects the register position |
| reg_index | input | 32 | Register operand; its low five bits give the position |
| imm_index | input | 4 | Immediate bit position |
| flags_in | input | 32 | Current packed flag word |
| flags_out | output | 32 | Updated flag word, valid while `flags_we` is high |
| flags_we | output | 1 | One-cycle write enable for `flags_out` |

## Verification
The hardest case to reach from the ports is the top position. Position 31 is only reachable in register form, and it distinguishes the full-width zero test from a mask that has overflowed. A random data word almost never has all bits below bit 31 clear. The stimulus therefore drives position 31 with the words 0, 0x80000000 and 1 on purpose. It also sets the register operand's upper bits to ones, so that a decode using too many index bits shows up. Random traffic with sparse data words and back-to-back and idle cycles then covers both index forms against a behavioural model that is checked on every clock.

// File: rtl/btst_pkg.sv
package btst_pkg;
  // Flag word bit positions
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_X = 4;
endpackage

// File: rtl/btst_index_sel.sv
module btst_index_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 4,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic             use_imm,
  input  logic [IDX_W-1:0] reg_low,
  input  logic [IMM_W-1:0] imm_index,
  output logic [IDX_W-1:0] sel_idx
);
  always_comb begin
    if (use_imm) sel_idx = IDX_W'(imm_index);
    else         sel_idx = reg_low;
  end
endmodule

// File: rtl/btst_eval.sv
module btst_eval #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [IDX_W-1:0]  idx,
  output logic              bit_val,
  output logic              low_zero
);
  logic [DATA_W-1:0] lo_mask;

  // Inclusive thermometer mask built per bit: no shift, so no overflow at the top position
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign lo_mask[g] = (idx >= IDX_W'(g));
  end

  assign bit_val  = data[idx];
  assign low_zero = ~|(data & lo_mask);
endmodule

// File: rtl/btst_flag_merge.sv
module btst_flag_merge
  import btst_pkg::*;
#(
  parameter int unsigned FLAG_W = 32
) (
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              bit_val,
  input  logic              low_zero,
  output logic [FLAG_W-1:0] flags_next
);
  always_comb begin
    flags_next        = flags_in;
    flags_next[FLG_N] = bit_val;
    flags_next[FLG_Z] = low_zero;
    flags_next[FLG_X] = 1'b0;
  end
endmodule

// File: rtl/btst_unit.sv
module btst_unit
  import btst_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 4,
  parameter int unsigned FLAG_W = 32,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] reg_index,
  input  logic [IMM_W-1:0]  imm_index,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out,
  output logic              flags_we
);
  localparam logic [FLAG_W-1:0] TOUCHED =
    FLAG_W'((64'd1 << FLG_N) | (64'd1 << FLG_Z) | (64'd1 << FLG_X));

  logic [IDX_W-1:0]  sel_idx;
  logic              bit_val;
  logic              low_zero;
  logic [FLAG_W-1:0] flags_next;
  logic              unused_hi;

  assign unused_hi = ^reg_index[DATA_W-1:IDX_W];

  btst_index_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .use_imm   (use_imm),
    .reg_low   (reg_index[IDX_W-1:0]),
    .imm_index (imm_index),
    .sel_idx   (sel_idx)
  );

  btst_eval #(.DATA_W(DATA_W)) u_eval (
    .data     (in_data),
    .idx      (sel_idx),
    .bit_val  (bit_val),
    .low_zero (low_zero)
  );

  btst_flag_merge #(.FLAG_W(FLAG_W)) u_merge (
    .flags_in   (flags_in),
    .bit_val    (bit_val),
    .low_zero   (low_zero),
    .flags_next (flags_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_out <= '0;
      flags_we  <= 1'b0;
    end else begin
      flags_we <= in_valid;
      if (in_valid) flags_out <= flags_next;
    end
  end

  // R8
  we_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> flags_we);
  // R8
  we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!flags_we && $stable(flags_out)));
  // R6
  x_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> !flags_out[FLG_X]);
  // R7
  keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((flags_out ^ $past(flags_in)) & ~TOUCHED) == '0));
  // R3
  n_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flags_out[FLG_N] == $past(in_data[sel_idx])));
  // R5
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_idx == '1) |=> (flags_out[FLG_Z] == ($past(in_data) == '0)));
endmodule

// File: tb/tb_btst_unit.sv
`timescale 1ns/1ps
module tb_btst_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        use_imm;
  logic [31:0] reg_index;
  logic [3:0]  imm_index;
  logic [31:0] flags_in;
  logic [31:0] flags_out;
  logic        flags_we;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_flags = '0;

  always #2.5 clk = ~clk;

  btst_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .use_imm(use_imm), .reg_index(reg_index), .imm_index(imm_index),
    .flags_in(flags_in), .flags_out(flags_out), .flags_we(flags_we)
  );

  function automatic logic [31:0] model(input logic [31:0] d, input int pos,
                                        input logic [31:0] f);
    logic [31:0] r;
    logic z;
    r = f;
    z = 1'b1;
    for (int i = 0; i <= pos; i++) if (d[i]) z = 1'b0;
    r[3] = d[pos];
    r[2] = z;
    r[4] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare one cycle later at negedge
  task automatic step(input bit v, input logic [31:0] d, input bit imm,
                      input logic [31:0] ri, input logic [3:0] ii,
                      input logic [31:0] f, input string req);
    int pos;
    in_valid = v; in_data = d; use_imm = imm; reg_index = ri;
    imm_index = ii; flags_in = f;
    pos = imm ? int'(ii) : int'(ri % 32);
    if (v) exp_flags = model(d, pos, f);
    @(negedge clk);
    check({req, " we"}, {31'b0, flags_we}, {31'b0, v});
    check({req, " flags"}, flags_out, exp_flags);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; in_data = '1; use_imm = 0;
    reg_index = 0; imm_index = 0; flags_in = '1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 we", {31'b0, flags_we}, 32'd0);
    check("R9 flags", flags_out, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after release", {31'b0, flags_we} | flags_out, 32'd0);

    step(1, 32'h0000_0001, 0, 32'd0, 4'd0, 32'h0, "R3 pos0 set");
    step(1, 32'h0000_0000, 0, 32'd0, 4'd0, 32'h0, "R4 pos0 clear");
    step(1, 32'h0000_0000, 0, 32'd31, 4'd0, 32'hFFFF_FFFF, "R5 pos31 zero word");
    step(1, 32'h8000_0000, 0, 32'd31, 4'd0, 32'h0, "R5 pos31 top bit");
    step(1, 32'h0000_0001, 0, 32'd31, 4'd0, 32'h0, "R5 pos31 low bit");
    step(1, 32'h0000_0010, 0, 32'hFFFF_FFE5, 4'd0, 32'h0, "R1 upper index bits");
    step(1, 32'h0000_0040, 0, 32'hFFFF_FFE5, 4'd0, 32'h0, "R1 upper bits above");
    step(1, 32'h0000_8000, 1, 32'd3, 4'd15, 32'h0, "R2 imm 15");
    step(1, 32'h0001_0000, 1, 32'd16, 4'd15, 32'h0, "R2 imm ignores reg");
    step(1, 32'h0000_0004, 0, 32'd2, 4'd0, 32'hFFFF_FFFF, "R6 R7 all flags set");
    step(1, 32'h0000_0000, 0, 32'd7, 4'd0, 32'hA5A5_A5A5, "R7 pattern");
    step(0, 32'hFFFF_FFFF, 0, 32'd1, 4'd0, 32'h0, "R8 idle holds");
    step(0, 32'h0, 1, 32'd0, 4'd9, 32'h1234_5678, "R8 idle holds again");
    step(1, 32'h0000_0100, 0, 32'd9, 4'd0, 32'h0, "R4 lower bit below pos");
    step(1, 32'h0000_0200, 0, 32'd8, 4'd0, 32'h0, "R4 bit above pos");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] d;
      d = $urandom() & $urandom() & $urandom();
      if ((n % 5) == 0) d = 32'h1 << ($urandom() % 32);
      step(($urandom() % 4) != 0, d, $urandom() % 2, $urandom(),
           4'($urandom()), $urandom(), "R3 R4 R7 R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule